// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This combinational unit builds the second source operand of a 32-bit data-processing instruction and the carry that the shifter produces. It reads the 12-bit operand field of the instruction and a form bit. It also takes the value of the register to be shifted, the low byte of the register that holds a shift amount, and the current carry flag. It drives the 32-bit operand, a carry-out and a carry-valid flag. It also drives the two register indices that the register file needs, so that it can supply the shifted value and the amount.

There are three operand forms. An 8-bit constant can be rotated by an even amount. A register can be shifted by a 5-bit constant. A register can be shifted by an amount held in another register. Each form uses one of four shift kinds: logical left, logical right, arithmetic right and rotate right. Some encodings mean "keep the old carry". In those cases carry-valid goes low and the carry-out repeats the carry input, so the flag logic downstream can leave its flag alone.

Top module: `shifter_operand_unit`

## Requirements
- R1: When `immForm` is 1, the operand is `opField[7:0]`, zero-extended and rotated right by twice the value of `opField[11:8]`.
- R2: In the constant form, a nonzero rotate field gives carryOut equal to operand bit 31 with carryValid 1. A zero rotate field keeps the carry.
- R3: `opRegSel` equals `opField[3:0]` and `amtRegSel` equals `opField[11:8]`. With `immForm` 0, `opField[4]` picks the register amount (1) or the 5-bit constant amount `opField[11:7]` (0). `opField[6:5]` picks the kind: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right.
- R4: A logical left shift by a constant s in 1..31 gives the value shifted left, with carryOut equal to input bit 32−s. A constant amount of 0 passes the value through and keeps the carry.
- R5: With a constant amount of 0, logical right gives 0 with carryOut equal to input bit 31. Arithmetic right fills every bit with input bit 31 and sets carryOut to it.
- R6: A right shift or rotate by a constant s in 1..31 sets carryOut to input bit s−1.
- R7: A rotate right with a constant amount of 0 shifts right by one bit, with carryIn entering bit 31 and input bit 0 becoming carryOut.
- R8: In the register form, the amount is `amtLow`, the low 8 bits of the amount register. An amount of 0 passes the value through and keeps the carry.
- R9: For register amounts of 32 or more, logical left and logical right give 0. At exactly 32 the carry is input bit 0 for left and input bit 31 for right. Above 32 the carry is 0.
- R10: For register amounts of 32 or more, arithmetic right fills every bit with input bit 31 and sets carryOut to it.
- R11: A register rotate uses the amount modulo 32. A nonzero multiple of 32 leaves the value unchanged with carryOut equal to input bit 31.
- R12: carryValid is 0 exactly when the carry is kept, and then carryOut equals carryIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| immForm | input | 1 | 1 selects the rotated-constant form |
| opField | input | 12 | Operand field of the instruction |
| opRegVal | input | 32 | Value of the register being shifted |
| amtLow | input | 8 | Low byte of the amount register |
| carryIn | input | 1 | Current carry flag |
| opRegSel | output | 4 | Index of the register being shifted |
| amtRegSel | output | 4 | Index of the amount register |
| operand | output | 32 | Shifted second operand |
| carryOut | output | 1 | Shifter carry |
| carryValid | output | 1 | 0 when the old carry must be kept |

## Verification
The bench goes after every encoding where a zero amount changes meaning. A right shift by a constant 0 that is treated as no shift would return the input unchanged instead of 0 or a sign fill. A constant rotate by 0 that is not taken as the one-bit rotate through carry would lose the incoming carry at bit 31.

Register amounts of exactly 32, above 32, and 255 are applied to each kind. A shifter that truncated the amount to 5 bits would return the unshifted value. One that mishandled the boundary at 32 would give the wrong carry at 32 or a stray carry above it.

Carry-keep cases are checked with both carry polarities. A design that drove its own carry there would be caught through carryOut and carryValid.

// File: rtl/shop_pkg.sv
package shop_pkg;
  parameter int REG_AMT_BITS = 8;
  localparam int AMT_W = REG_AMT_BITS + 1;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shKind_e;

  typedef struct packed {
    logic             useImm;
    shKind_e          kind;
    logic [AMT_W-1:0] amount;
    logic             rrx;
    logic             keepCarry;
  } shStrobe_t;
endpackage

// File: rtl/shop_ctrl.sv
module shop_ctrl
  import shop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                    immForm,
  input  logic [11:0]             opField,
  input  logic [REG_AMT_BITS-1:0] amtLow,
  output shStrobe_t               strobe
);
  logic [4:0] immAmt;

  always_comb begin
    strobe        = '0;
    immAmt        = opField[11:7];
    strobe.kind   = shKind_e'(opField[6:5]);
    if (immForm) begin
      strobe.useImm    = 1'b1;
      strobe.kind      = SH_ROR;
      strobe.amount    = AMT_W'({opField[11:8], 1'b0});
      strobe.keepCarry = (opField[11:8] == 4'd0);
    end else if (opField[4]) begin
      strobe.amount    = AMT_W'(amtLow);
      strobe.keepCarry = (amtLow == '0);
    end else begin
      strobe.amount = AMT_W'(immAmt);
      if (immAmt == 5'd0) begin
        unique case (strobe.kind)
          SH_LSL:         strobe.keepCarry = 1'b1;
          SH_LSR, SH_ASR: strobe.amount    = AMT_W'(DATA_W);
          SH_ROR:         strobe.rrx       = 1'b1;
          default:        strobe.keepCarry = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/shop_datapath.sv
module shop_datapath
  import shop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input  shStrobe_t         strobe,
  input  logic [IMM_W-1:0]  immByte,
  input  logic [DATA_W-1:0] opRegVal,
  input  logic              carryIn,
  output logic [DATA_W-1:0] operand,
  output logic              carryOut,
  output logic              carryValid
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0]        src;
  logic [DATA_W:0]          lslWide;
  logic [DATA_W:0]          lsrWide;
  logic signed [DATA_W:0]   asrWide;
  logic [AMT_W-1:0]         asrAmt;
  logic [SH_W-1:0]          rorAmt;
  logic [DATA_W-1:0]        rorVal;

  assign src = strobe.useImm ? DATA_W'(immByte) : opRegVal;

  always_comb begin
    lslWide = {1'b0, src} << strobe.amount;
    lsrWide = {src, 1'b0} >> strobe.amount;
    asrAmt  = (strobe.amount > AMT_W'(DATA_W)) ? AMT_W'(DATA_W) : strobe.amount;
    asrWide = $signed({src, 1'b0}) >>> asrAmt;
    rorAmt  = strobe.amount[SH_W-1:0];
    rorVal  = (src >> rorAmt) | (src << (DATA_W - {1'b0, rorAmt}));
  end

  always_comb begin
    operand    = src;
    carryOut   = carryIn;
    carryValid = 1'b1;
    if (strobe.keepCarry) begin
      carryValid = 1'b0;
    end else if (strobe.rrx) begin
      operand  = {carryIn, src[DATA_W-1:1]};
      carryOut = src[0];
    end else begin
      unique case (strobe.kind)
        SH_LSL: begin
          operand  = lslWide[DATA_W-1:0];
          carryOut = lslWide[DATA_W];
        end
        SH_LSR: begin
          operand  = lsrWide[DATA_W:1];
          carryOut = lsrWide[0];
        end
        SH_ASR: begin
          operand  = asrWide[DATA_W:1];
          carryOut = asrWide[0];
        end
        default: begin
          operand  = rorVal;
          carryOut = rorVal[DATA_W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/shifter_operand_unit.sv
module shifter_operand_unit
  import shop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                    immForm,
  input  logic [11:0]             opField,
  input  logic [DATA_W-1:0]       opRegVal,
  input  logic [REG_AMT_BITS-1:0] amtLow,
  input  logic                    carryIn,
  output logic [3:0]              opRegSel,
  output logic [3:0]              amtRegSel,
  output logic [DATA_W-1:0]       operand,
  output logic                    carryOut,
  output logic                    carryValid
);
  localparam int IMM_W = 8;

  shStrobe_t strobe;

  assign opRegSel  = opField[3:0];
  assign amtRegSel = opField[11:8];

  shop_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .immForm (immForm),
    .opField (opField),
    .amtLow  (amtLow),
    .strobe  (strobe)
  );

  shop_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .strobe     (strobe),
    .immByte    (opField[IMM_W-1:0]),
    .opRegVal   (opRegVal),
    .carryIn    (carryIn),
    .operand    (operand),
    .carryOut   (carryOut),
    .carryValid (carryValid)
  );
endmodule

// File: rtl/shifter_operand_unit_chk.sv
module shifter_operand_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              immForm,
  input logic [11:0]       opField,
  input logic [DATA_W-1:0] opRegVal,
  input logic [7:0]        amtLow,
  input logic              carryIn,
  input logic [DATA_W-1:0] operand,
  input logic              carryOut,
  input logic              carryValid
);
  logic known;
  assign known = !$isunknown({immForm, opField, opRegVal, amtLow, carryIn});

  always_comb begin
    if (known) begin
      if (!carryValid)
        assert_keep_carry_R12: assert (carryOut == carryIn);
      if (immForm && opField[11:8] != 4'd0)
        assert_imm_carry_R2: assert (carryValid && carryOut == operand[DATA_W-1]);
      if (!immForm && !opField[4] && opField[6:5] == 2'd3 && opField[11:7] == 5'd0)
        assert_rrx_R7: assert (operand == {carryIn, opRegVal[DATA_W-1:1]} && carryOut == opRegVal[0]);
      if (!immForm && opField[4] && amtLow == 8'd0)
        assert_reg_zero_R8: assert (operand == opRegVal && !carryValid);
      if (!immForm && opField[4] && opField[6:5] == 2'd0 && amtLow > 8'd32)
        assert_lsl_big_R9: assert (operand == '0 && !carryOut);
      if (!immForm && opField[4] && opField[6:5] == 2'd2 && amtLow >= 8'd32)
        assert_asr_big_R10: assert (operand == {DATA_W{opRegVal[DATA_W-1]}} && carryOut == opRegVal[DATA_W-1]);
    end
  end
endmodule

bind shifter_operand_unit shifter_operand_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .immForm    (immForm),
  .opField    (opField),
  .opRegVal   (opRegVal),
  .amtLow     (amtLow),
  .carryIn    (carryIn),
  .operand    (operand),
  .carryOut   (carryOut),
  .carryValid (carryValid)
);

// File: tb/shifter_operand_unit_tb.sv
module shifter_operand_unit_tb;
  logic        clk = 1'b0;
  logic        immForm;
  logic [11:0] opField;
  logic [31:0] opRegVal;
  logic [7:0]  amtLow;
  logic        carryIn;
  logic [3:0]  opRegSel;
  logic [3:0]  amtRegSel;
  logic [31:0] operand;
  logic        carryOut;
  logic        carryValid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  shifter_operand_unit u_dut (
    .immForm    (immForm),
    .opField    (opField),
    .opRegVal   (opRegVal),
    .amtLow     (amtLow),
    .carryIn    (carryIn),
    .opRegSel   (opRegSel),
    .amtRegSel  (amtRegSel),
    .operand    (operand),
    .carryOut   (carryOut),
    .carryValid (carryValid)
  );

  function automatic logic [11:0] fImm(input logic [3:0] rot, input logic [7:0] b);
    return {rot, b};
  endfunction
  function automatic logic [11:0] fShImm(input logic [4:0] s, input logic [1:0] k, input logic [3:0] rm);
    return {s, k, 1'b0, rm};
  endfunction
  function automatic logic [11:0] fShReg(input logic [3:0] rs, input logic [1:0] k, input logic [3:0] rm);
    return {rs, 1'b0, k, 1'b1, rm};
  endfunction

  task automatic runCase(input string tag, input logic imm, input logic [11:0] f,
                         input logic [31:0] rv, input logic [7:0] amt, input logic cin,
                         input logic [31:0] expV, input logic expC, input logic expValid);
    @(negedge clk);
    immForm = imm; opField = f; opRegVal = rv; amtLow = amt; carryIn = cin;
    #1;
    checks++;
    if (operand !== expV || carryOut !== expC || carryValid !== expValid) begin
      errors++;
      $display("FAIL %s: operand=%h carry=%b valid=%b expected operand=%h carry=%b valid=%b",
               tag, operand, carryOut, carryValid, expV, expC, expValid);
    end
  endtask

  task automatic t_idle;
    runCase("R12 idle zero inputs", 1'b0, 12'h000, 32'h0, 8'h0, 1'b0, 32'h0, 1'b0, 1'b0);
    runCase("R12 keep carry high", 1'b0, 12'h000, 32'h0, 8'h0, 1'b1, 32'h0, 1'b1, 1'b0);
  endtask

  task automatic t_immediate;
    runCase("R2 rot zero keeps carry", 1'b1, fImm(4'd0, 8'hAB), 32'h0, 8'h0, 1'b1, 32'h000000AB, 1'b1, 1'b0);
    runCase("R1 rot 8", 1'b1, fImm(4'd4, 8'hFF), 32'h0, 8'h0, 1'b0, 32'hFF000000, 1'b1, 1'b1);
    runCase("R1 rot 2", 1'b1, fImm(4'd1, 8'h03), 32'h0, 8'h0, 1'b0, 32'hC0000000, 1'b1, 1'b1);
    runCase("R2 rot 30 carry 0", 1'b1, fImm(4'd15, 8'h81), 32'h0, 8'h0, 1'b1, 32'h00000204, 1'b0, 1'b1);
  endtask

  task automatic t_lslImm;
    runCase("R4 lsl 0 passes", 1'b0, fShImm(5'd0, 2'd0, 4'd2), 32'h80000001, 8'h0, 1'b1, 32'h80000001, 1'b1, 1'b0);
    runCase("R4 lsl 1", 1'b0, fShImm(5'd1, 2'd0, 4'd2), 32'h80000001, 8'h0, 1'b0, 32'h00000002, 1'b1, 1'b1);
    runCase("R4 lsl 31", 1'b0, fShImm(5'd31, 2'd0, 4'd2), 32'h00000003, 8'h0, 1'b0, 32'h80000000, 1'b1, 1'b1);
  endtask

  task automatic t_rightImm;
    runCase("R5 lsr 0 means 32", 1'b0, fShImm(5'd0, 2'd1, 4'd1), 32'h80000000, 8'h0, 1'b0, 32'h0, 1'b1, 1'b1);
    runCase("R5 asr 0 negative", 1'b0, fShImm(5'd0, 2'd2, 4'd1), 32'h80000000, 8'h0, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b1);
    runCase("R5 asr 0 positive", 1'b0, fShImm(5'd0, 2'd2, 4'd1), 32'h7FFFFFFF, 8'h0, 1'b1, 32'h0, 1'b0, 1'b1);
    runCase("R6 lsr 4", 1'b0, fShImm(5'd4, 2'd1, 4'd1), 32'h00000018, 8'h0, 1'b0, 32'h00000001, 1'b1, 1'b1);
    runCase("R6 asr 4", 1'b0, fShImm(5'd4, 2'd2, 4'd1), 32'hF0000008, 8'h0, 1'b0, 32'hFF000000, 1'b1, 1'b1);
    runCase("R6 ror 8", 1'b0, fShImm(5'd8, 2'd3, 4'd1), 32'h12345678, 8'h0, 1'b1, 32'h78123456, 1'b0, 1'b1);
  endtask

  task automatic t_rrx;
    runCase("R7 rrx carry in 1", 1'b0, fShImm(5'd0, 2'd3, 4'd7), 32'h00000002, 8'h0, 1'b1, 32'h80000001, 1'b0, 1'b1);
    runCase("R7 rrx carry in 0", 1'b0, fShImm(5'd0, 2'd3, 4'd7), 32'h00000003, 8'h0, 1'b0, 32'h00000001, 1'b1, 1'b1);
  endtask

  task automatic t_regZero;
    for (int k = 0; k < 4; k++)
      runCase("R8 reg amount 0", 1'b0, fShReg(4'd3, 2'(k), 4'd4), 32'hDEADBEEF, 8'h0, 1'(k & 1),
              32'hDEADBEEF, 1'(k & 1), 1'b0);
    runCase("R8 reg lsl 4", 1'b0, fShReg(4'd3, 2'd0, 4'd4), 32'h1000000F, 8'd4, 1'b0, 32'h000000F0, 1'b1, 1'b1);
  endtask

  task automatic t_regLarge;
    runCase("R9 lsl 32", 1'b0, fShReg(4'd1, 2'd0, 4'd2), 32'h00000001, 8'd32, 1'b0, 32'h0, 1'b1, 1'b1);
    runCase("R9 lsl 33", 1'b0, fShReg(4'd1, 2'd0, 4'd2), 32'hFFFFFFFF, 8'd33, 1'b1, 32'h0, 1'b0, 1'b1);
    runCase("R9 lsr 32", 1'b0, fShReg(4'd1, 2'd1, 4'd2), 32'h80000000, 8'd32, 1'b0, 32'h0, 1'b1, 1'b1);
    runCase("R9 lsr 200", 1'b0, fShReg(4'd1, 2'd1, 4'd2), 32'hFFFFFFFF, 8'd200, 1'b1, 32'h0, 1'b0, 1'b1);
    runCase("R10 asr 32 negative", 1'b0, fShReg(4'd1, 2'd2, 4'd2), 32'h80000000, 8'd32, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b1);
    runCase("R10 asr 255 positive", 1'b0, fShReg(4'd1, 2'd2, 4'd2), 32'h7FFFFFFF, 8'd255, 1'b1, 32'h0, 1'b0, 1'b1);
  endtask

  task automatic t_regRor;
    runCase("R11 ror 32", 1'b0, fShReg(4'd6, 2'd3, 4'd9), 32'h80000000, 8'd32, 1'b0, 32'h80000000, 1'b1, 1'b1);
    runCase("R11 ror 64", 1'b0, fShReg(4'd6, 2'd3, 4'd9), 32'h00000001, 8'd64, 1'b1, 32'h00000001, 1'b0, 1'b1);
    runCase("R11 ror 36", 1'b0, fShReg(4'd6, 2'd3, 4'd9), 32'h12345678, 8'd36, 1'b0, 32'h81234567, 1'b1, 1'b1);
    runCase("R11 ror 1", 1'b0, fShReg(4'd6, 2'd3, 4'd9), 32'h00000001, 8'd1, 1'b0, 32'h80000000, 1'b1, 1'b1);
  endtask

  task automatic t_select;
    @(negedge clk);
    immForm = 1'b0; opField = fShReg(4'hA, 2'd1, 4'h5); opRegVal = 32'h0; amtLow = 8'd0; carryIn = 1'b0;
    #1;
    checks++;
    if (opRegSel !== 4'h5 || amtRegSel !== 4'hA) begin
      errors++;
      $display("FAIL R3 register selects: opRegSel=%h amtRegSel=%h expected 5 and a", opRegSel, amtRegSel);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    immForm = 1'b0; opField = '0; opRegVal = '0; amtLow = '0; carryIn = 1'b0;
    repeat (2) @(posedge clk);
    t_idle();
    t_immediate();
    t_lslImm();
    t_rightImm();
    t_rrx();
    t_regZero();
    t_regLarge();
    t_regRor();
    t_select();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule